// File: doc/BRIEF.md
# Presence-detect EEPROM slave

This block is the serial memory that lets a host identify a memory module on a shared two-wire bus. It models a 256-byte EEPROM, filled at reset with identification bytes, behind an I2C-style slave interface. The bus clock and data lines are oversampled on a fast system clock. The slave pulls the data line low through an open-drain output enable and never drives it high.

Three board-strap inputs form the low part of the device address, so eight modules can share one bus. The host can read at a random address: it writes a word address, issues a repeated START, then reads. It can also read sequentially with an auto-incrementing address, read at the current address, or write single bytes. While the write-lock input is high, writes are acknowledged but the array keeps its contents. Each write that a STOP closes starts an internal write window of a programmable number of clock cycles. During that window the slave ignores its own address.

Top module: `pdmem_slave`

## Requirements
- R1: The slave acknowledges only a device-select byte whose upper seven bits are 1010 followed by `board_id[2:0]`; bit 0 is the direction bit (1 = read). On any other byte the data line stays released.
- R2: After reset the array reads 80h at byte 0, 08h at byte 1, 07h at byte 2, 0Dh at byte 3 and 0Ah at byte 4. Byte 63 equals the sum of bytes 0 to 62 modulo 256, and bytes 64 to 255 read 00h.
- R3: A write transfer (device select with bit 0 = 0, word address, one data byte) is acknowledged on all three bytes and stores the data byte at the word address.
- R4: A random read is a device select for writing plus a word address, then a repeated START and a device select for reading. It returns the byte at that address.
- R5: The word address increments after every byte read or written and wraps from 255 to 0. A read that follows its device select directly starts at the current address.
- R6: While `wr_lock` is high, a write transfer is still acknowledged on every byte, but the array is left unchanged.
- R7: A STOP that ends a transfer containing a stored data byte starts a window of `WR_CYCLES` clock cycles. During the window no device select is acknowledged. After the window, device selects are acknowledged again.
- R8: A START at any point restarts device-select decoding. A STOP at any point returns the slave to idle with the data line released.
- R9: Only the first data byte of a write transfer is accepted. A further data byte is not acknowledged and is not stored.
- R10: The slave starts pulling the data line low only while SCL is low.
- R11: During and after reset the data line is released, and the slave pulls it low only in an acknowledge slot or while it sends a read data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset; reloads the array |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| board_id | input | 3 | Strap inputs selecting the low device-address bits |
| wr_lock | input | 1 | High blocks array updates from bus writes |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
The hardest behaviour to reach is the write window. The host has to close a write with a STOP and then present a device select before `WR_CYCLES` cycles have passed. The bench therefore sends a START and a device select straight after such a STOP and expects no acknowledge. It then waits past the window and repeats the select, which must be acknowledged. A NACK for a repeat byte within the same write, and a restart in the middle of a byte, are reached by driving a partial byte or an extra data byte from the bench's own bit-level bus tasks.

// File: rtl/pdmem_pkg.sv
package pdmem_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  DEV_TYPE = 4'b1010;
    localparam int          SUM_LAST = 62;
    localparam int          SUM_POS  = 63;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADR,
        ST_ADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    // Identification bytes; positions are decoded by the host.
    function automatic logic [BYTE_W-1:0] id_byte(input int idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'h08;
            2:       return 8'h07;
            3:       return 8'h0D;
            4:       return 8'h0A;
            5:       return 8'h01;
            6:       return 8'h40;
            9:       return 8'h60;
            12:      return 8'h82;
            17:      return 8'h04;
            18:      return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] preload_byte(input int idx);
        logic [BYTE_W-1:0] acc;
        acc = '0;
        if (idx == SUM_POS) begin
            for (int i = 0; i <= SUM_LAST; i++) acc = acc + id_byte(i);
            return acc;
        end
        if (idx < SUM_POS) return id_byte(idx);
        return '0;
    endfunction

endpackage

// File: rtl/pdmem_linesync.sv
module pdmem_linesync
    import pdmem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    logic [STAGES:0] scl_p;
    logic [STAGES:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_in};
            sda_p <= {sda_p[STAGES-1:0], sda_in};
        end
    end

    logic scl_cur, scl_prv, sda_cur, sda_prv;
    assign scl_cur = scl_p[STAGES-1];
    assign scl_prv = scl_p[STAGES];
    assign sda_cur = sda_p[STAGES-1];
    assign sda_prv = sda_p[STAGES];

    always_comb begin
        ev.scl_rise = scl_cur & ~scl_prv;
        ev.scl_fall = ~scl_cur & scl_prv;
        ev.start    = scl_cur & scl_prv & sda_prv & ~sda_cur;
        ev.stop     = scl_cur & scl_prv & ~sda_prv & sda_cur;
        ev.sda      = sda_cur;
    end

endmodule

// File: rtl/pdmem_store.sv
module pdmem_store
    import pdmem_pkg::*;
#(
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              lock,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= preload_byte(i);
        end else if (we && !lock) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pdmem_busy.sv
module pdmem_busy #(
    parameter int CYCLES = 500,
    localparam int CW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic busy
);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)            left <= '0;
        else if (arm)       left <= CW'(CYCLES);
        else if (left != 0) left <= left - 1'b1;
    end

    assign busy = (left != 0);

endmodule

// File: rtl/pdmem_slave.sv
module pdmem_slave
    import pdmem_pkg::*;
#(
    parameter int MEM_DEPTH   = 256,
    parameter int WR_CYCLES   = 500,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(MEM_DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] board_id,
    input  logic       wr_lock,
    output logic       sda_oe
);

    line_ev_t          ev;
    phase_e            state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [ADDR_W-1:0] addr;
    logic              rd_mode;
    logic              byte_taken;
    logic              arm_pend;
    logic              host_more;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [BYTE_W-1:0] mem_wd;
    logic [BYTE_W-1:0] rdata;
    logic              busy;
    logic              busy_arm;

    pdmem_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    pdmem_store #(.DEPTH(MEM_DEPTH)) u_store (
        .clk(clk), .rst(rst), .we(mem_we), .lock(wr_lock),
        .waddr(mem_wa), .wdata(mem_wd), .raddr(addr), .rdata(rdata)
    );

    assign busy_arm = ev.stop & arm_pend;

    pdmem_busy #(.CYCLES(WR_CYCLES)) u_busy (
        .clk(clk), .rst(rst), .arm(busy_arm), .busy(busy)
    );

    logic dev_hit;
    assign dev_hit = (shreg[7:1] == {DEV_TYPE, board_id}) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            addr       <= '0;
            rd_mode    <= 1'b0;
            byte_taken <= 1'b0;
            arm_pend   <= 1'b0;
            host_more  <= 1'b0;
            sda_oe     <= 1'b0;
            mem_we     <= 1'b0;
            mem_wa     <= '0;
            mem_wd     <= '0;
        end else begin
            mem_we <= 1'b0;
            if (ev.stop) begin
                state      <= ST_IDLE;
                sda_oe     <= 1'b0;
                arm_pend   <= 1'b0;
                byte_taken <= 1'b0;
            end else if (ev.start) begin
                state      <= ST_DEV;
                bit_cnt    <= '0;
                sda_oe     <= 1'b0;
                byte_taken <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_ADR, ST_WDAT: begin
                        if (ev.scl_rise) begin
                            shreg   <= {shreg[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                if (dev_hit) begin
                                    rd_mode <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_ADR) begin
                                addr   <= shreg[ADDR_W-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADR_ACK;
                            end else if (!byte_taken) begin
                                mem_we     <= 1'b1;
                                mem_wa     <= addr;
                                mem_wd     <= shreg;
                                addr       <= addr + 1'b1;
                                byte_taken <= 1'b1;
                                arm_pend   <= 1'b1;
                                sda_oe     <= 1'b1;
                                state      <= ST_WDAT_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (ev.scl_fall) begin
                            if (rd_mode) begin
                                shreg   <= rdata;
                                sda_oe  <= ~rdata[7];
                                bit_cnt <= '0;
                                state   <= ST_RDAT;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_ADR;
                            end
                        end
                    end
                    ST_ADR_ACK, ST_WDAT_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDAT;
                        end
                    end
                    ST_RDAT: begin
                        if (ev.scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                addr   <= addr + 1'b1;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            host_more <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (host_more) begin
                                shreg   <= rdata;
                                sda_oe  <= ~rdata[7];
                                bit_cnt <= '0;
                                state   <= ST_RDAT;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pdmem_slave_chk.sv
module pdmem_slave_chk
    import pdmem_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   scl_in,
    input logic   sda_oe,
    input logic   busy,
    input logic   start_evt,
    input logic   stop_evt,
    input phase_e state
);

    // R7
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    // R10
    drive_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_in);

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (state == ST_IDLE) && !sda_oe);

    // R8
    start_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (start_evt && !stop_evt) |=> (state == ST_DEV));

    // R11
    drive_slot_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state inside {ST_DEV_ACK, ST_ADR_ACK, ST_WDAT_ACK, ST_RDAT}));

endmodule

bind pdmem_slave pdmem_slave_chk u_chk (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe), .busy(busy),
    .start_evt(ev.start), .stop_evt(ev.stop), .state(state)
);

// File: tb/pdmem_slave_test.sv
module pdmem_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int BUSY_CYC   = 500;
    localparam logic [2:0] MY_ID = 3'b101;
    localparam int NVEC = 8;
    // {address, expected preload byte}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'd0, 8'h80}, {8'd1, 8'h08}, {8'd2, 8'h07}, {8'd3, 8'h0D},
        {8'd4, 8'h0A}, {8'd63, 8'hD5}, {8'd64, 8'h00}, {8'd200, 8'h00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wr_lock = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic oe_prev = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   r10_bad = 0;
    logic [7:0] rd_buf [64];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdmem_slave #(.WR_CYCLES(BUSY_CYC)) uut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .board_id(MY_ID), .wr_lock(wr_lock), .sda_oe(sda_oe)
    );

    // R10 monitor: the slave may begin pulling low only while SCL is low
    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_prev && scl_m) r10_bad++;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tq();
        sda_m = 1'b0; tq();
        scl_m = 1'b0; tq();
    endtask

    task automatic bus_restart();
        sda_m = 1'b1; tq();
        scl_m = 1'b1; tq();
        sda_m = 1'b0; tq();
        scl_m = 1'b0; tq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tq();
        scl_m = 1'b1; tq();
        sda_m = 1'b1; tq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tq();
            scl_m = 1'b1; tq(); tq();
            scl_m = 1'b0; tq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tq();
        scl_m = 1'b1; tq();
        ack = ~sda_line; tq();
        scl_m = 1'b0; tq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tq();
            scl_m = 1'b1; tq();
            b[i] = sda_line; tq();
            scl_m = 1'b0; tq();
        end
        sda_m = ~mack; tq();
        scl_m = 1'b1; tq(); tq();
        scl_m = 1'b0; tq();
        sda_m = 1'b1;
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, output logic ok);
        logic k1, k2, k3;
        bus_start();
        send_byte({4'b1010, MY_ID, 1'b0}, k1);
        send_byte(a, k2);
        bus_restart();
        send_byte({4'b1010, MY_ID, 1'b1}, k3);
        for (int i = 0; i < n; i++) recv_byte(rd_buf[i], i < n - 1);
        bus_stop();
        ok = k1 & k2 & k3;
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d, output logic ok);
        logic k1, k2, k3;
        bus_start();
        send_byte({4'b1010, MY_ID, 1'b0}, k1);
        send_byte(a, k2);
        send_byte(d, k3);
        bus_stop();
        ok = k1 & k2 & k3;
    endtask

    task automatic wait_busy();
        repeat (BUSY_CYC + 100) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic ok, ack;
        logic [7:0] sum, b;

        repeat (3) @(negedge clk);
        chk("R11 released during reset", sda_oe, 1'b0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 released after reset", sda_oe, 1'b0);

        // R2 / R4: table of random reads against preload contents
        for (int i = 0; i < NVEC; i++) begin
            rand_read(VEC[i][15:8], 1, ok);
            chk("R4 random read acks", ok, 1'b1);
            chk("R2 preload byte", rd_buf[0], VEC[i][7:0]);
        end

        // R2 checksum, R5 sequential read
        rand_read(8'd0, 64, ok);
        sum = '0;
        for (int i = 0; i < 63; i++) sum = sum + rd_buf[i];
        chk("R2 checksum byte 63", rd_buf[63], sum);
        chk("R5 sequential byte 3", rd_buf[3], 8'h0D);

        // R5 read wrap 255 -> 0
        rand_read(8'd254, 3, ok);
        chk("R5 wrap to byte 0", rd_buf[2], 8'h80);

        // R1 mismatched selects
        bus_start();
        send_byte({4'b1010, ~MY_ID, 1'b1}, ack);
        bus_stop();
        chk("R1 wrong strap id not acked", ack, 1'b0);
        bus_start();
        send_byte({4'b1011, MY_ID, 1'b1}, ack);
        bus_stop();
        chk("R1 wrong type not acked", ack, 1'b0);

        // R3 write, R7 busy window
        write_one(8'd100, 8'h5A, ok);
        chk("R3 write acks", ok, 1'b1);
        bus_start();
        send_byte({4'b1010, MY_ID, 1'b0}, ack);
        bus_stop();
        chk("R7 select ignored while busy", ack, 1'b0);
        wait_busy();
        rand_read(8'd100, 1, ok);
        chk("R7 select acked after window", ok, 1'b1);
        chk("R3 written byte", rd_buf[0], 8'h5A);

        // R6 write lock
        wr_lock = 1'b1;
        write_one(8'd101, 8'hC3, ok);
        chk("R6 locked write acked", ok, 1'b1);
        wait_busy();
        wr_lock = 1'b0;
        rand_read(8'd101, 1, ok);
        chk("R6 locked byte unchanged", rd_buf[0], 8'h00);

        // R9 second data byte refused
        bus_start();
        send_byte({4'b1010, MY_ID, 1'b0}, ack);
        send_byte(8'd110, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        bus_stop();
        chk("R9 second data byte nacked", ack, 1'b0);
        wait_busy();
        rand_read(8'd110, 2, ok);
        chk("R9 first byte stored", rd_buf[0], 8'h11);
        chk("R9 second byte not stored", rd_buf[1], 8'h00);

        // R5 write wrap, then current-address read at 0
        write_one(8'd255, 8'h77, ok);
        wait_busy();
        bus_start();
        send_byte({4'b1010, MY_ID, 1'b1}, ack);
        recv_byte(b, 1'b0);
        bus_stop();
        chk("R5 current address after wrap", b, 8'h80);

        // R8 START in the middle of a byte
        bus_start();
        send_bits({4'b1010, MY_ID, 1'b0}, 3);
        bus_restart();
        send_byte({4'b1010, MY_ID, 1'b1}, ack);
        recv_byte(b, 1'b0);
        bus_stop();
        chk("R8 restart mid-byte acked", ack, 1'b1);

        // R8 STOP in the middle of the address byte
        bus_start();
        send_byte({4'b1010, MY_ID, 1'b0}, ack);
        send_bits(8'h5C, 4);
        bus_stop();
        repeat (5) @(negedge clk);
        chk("R8 released after stop", sda_oe, 1'b0);
        rand_read(8'd2, 1, ok);
        chk("R8 usable after stop", rd_buf[0], 8'h07);

        chk("R10 drive began only with SCL low", r10_bad, 0);
        finish_run();
    end

endmodule